// File: doc/BRIEF.md
# Programmable Card Clock Generator

This block derives a smart-card clock from a reference clock and holds the settings that govern it. A host on a shared parallel bus programs it through an active-low select line, a program strobe, a two-bit address and one data bit. Nothing is sampled except at the moment the select line goes low. Each capture does one of two things. With the program strobe low, it loads a divide ratio and a supply-class bit. With the strobe high, it issues a clock command: park low, park high or run.

The core clock `clk` runs at twice the reference rate. A divide ratio of N therefore gives a card clock whose high and low phases each last N core cycles. Both outputs are registered. The clock only changes level at the end of a counted phase, and a new ratio takes hold only where a low phase begins. As a result, no phase is ever cut short, whether the ratio changes, the clock stops or the clock restarts.

Top module: `card_clk_gen`

## Requirements
- R1: After reset, `card_clk` is low and stays low (parked), `vsel_5v` is 0 and the ratio is divide by 1.
- R2: A capture with `prog_n` low loads ratio code `addr` (0: /1, 1: /2, 2: /4, 3: /8). While running, each high and each low phase of `card_clk` lasts 2^`addr` core cycles.
- R3: That same capture loads `dsel` into `vsel_5v` (1 selects 5 V, 0 selects 3 V). The output changes on the edge that sees the select fall.
- R4: Captures happen only on a high-to-low transition of `sel_n`. Changes to `prog_n`, `addr` or `dsel` while `sel_n` stays low have no effect, and this includes `prog_n` going back high.
- R5: While `sel_n` is high, every value on `prog_n`, `addr` and `dsel` is ignored.
- R6: A command capture (`prog_n` high, `addr` = 00) lets the current high phase finish and then holds `card_clk` low.
- R7: A command capture with `addr` = 01 lets the current low phase finish and then holds `card_clk` high.
- R8: A command capture with `addr` = 10 restarts the clock at the end of the current phase. `addr` = 11 changes nothing.
- R9: Every phase of `card_clk` lasts at least 2^code cycles for the ratio in force during that phase, so a ratio change never produces a phase shorter than the smaller of the old and new half periods.
- R10: Ratio and supply can be written while the clock is parked. The clock stays parked, and the new ratio applies once it is restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select; its falling edge captures |
| prog_n | input | 1 | Low: load ratio/supply; high: clock command |
| addr | input | ADDR_W | Ratio code or command code |
| dsel | input | 1 | Supply-class bit for a ratio load |
| card_clk | output | 1 | Registered card clock |
| vsel_5v | output | 1 | Latched supply-class select (1 = 5 V) |

## Verification
The assertions assume that all bus inputs are synchronous to `clk`. They also assume that `sel_n` is high for at least one sampled cycle between captures, since a select held low is one capture however long it lasts. The stimulus changes inputs only on falling clock edges and keeps the select low for several cycles on every access. It releases the select only after the strobe and data have been moved, which exercises the latching without breaking those assumptions. Phase lengths are measured by counting samples between level changes and are compared with 2^code computed in the bench.

// File: rtl/ccg_pkg.sv
package ccg_pkg;
  // Command codes decoded from addr when prog_n is high at capture
  typedef enum logic [1:0] {
    CMD_PARK_LO = 2'b00,
    CMD_PARK_HI = 2'b01,
    CMD_RUN     = 2'b10,
    CMD_NOP     = 2'b11
  } clk_cmd_e;
endpackage

// File: rtl/ccg_prog_if.sv
module ccg_prog_if #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dsel,
  output logic [ADDR_W-1:0] ratio_q,
  output logic              supply_q,
  output logic              run_q,
  output logic              park_q
);
  import ccg_pkg::*;

  logic sel_q;
  logic fall;
  clk_cmd_e cmd;

  assign fall = sel_q && !sel_n;
  assign cmd  = clk_cmd_e'(addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b1;
    else     sel_q <= sel_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q  <= '0;
      supply_q <= 1'b0;
      run_q    <= 1'b0;
      park_q   <= 1'b0;
    end else if (fall) begin
      if (!prog_n) begin
        ratio_q  <= addr;
        supply_q <= dsel;
      end else begin
        case (cmd)
          CMD_PARK_LO: begin run_q <= 1'b0; park_q <= 1'b0; end
          CMD_PARK_HI: begin run_q <= 1'b0; park_q <= 1'b1; end
          CMD_RUN:     run_q <= 1'b1;
          default:     ;
        endcase
      end
    end
  end

  AST_CS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sel_n && sel_q) |=> ($stable(ratio_q) && $stable(supply_q) && $stable(run_q) && $stable(park_q))); // R5

  AST_SUPPLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (fall && !prog_n) |=> (supply_q == $past(dsel))); // R3

  AST_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !sel_q) |=> ($stable(ratio_q) && $stable(run_q) && $stable(park_q))); // R4
endmodule

// File: rtl/ccg_phase_div.sv
module ccg_phase_div #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ratio_req,
  input  logic              run_req,
  input  logic              park_req,
  output logic              clk_q
);
  localparam int CNT_W = (1 << ADDR_W) - 1;
  localparam int SEG_W = CNT_W + 2;

  function automatic logic [SEG_W-1:0] half_of(input logic [ADDR_W-1:0] r);
    return SEG_W'(1) << r;
  endfunction

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] act_q;
  logic [ADDR_W-1:0] ratio_nxt;
  logic [SEG_W-1:0]  half_nxt;
  logic [CNT_W-1:0]  reload;
  logic              phase_end;
  logic              hold;
  logic              next_lvl;
  logic [SEG_W-1:0]  seg_q;

  assign phase_end = (cnt_q == '0);

  always_comb begin
    hold      = !run_req && (clk_q == park_req);
    next_lvl  = hold ? clk_q : !clk_q;
    // a new ratio is adopted only where a low phase starts
    ratio_nxt = next_lvl ? act_q : ratio_req;
    half_nxt  = half_of(ratio_nxt);
    reload    = CNT_W'(half_nxt - SEG_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
      act_q <= '0;
    end else if (phase_end) begin
      clk_q <= next_lvl;
      act_q <= ratio_nxt;
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // length of the current card-clock level, used by the phase check
  always_ff @(posedge clk) begin
    if (rst)                                   seg_q <= SEG_W'(1);
    else if (phase_end && next_lvl != clk_q)   seg_q <= SEG_W'(1);
    else if (seg_q != '1)                      seg_q <= seg_q + 1'b1;
  end

  AST_MIN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (phase_end && next_lvl != clk_q) |-> (seg_q >= half_of(act_q))); // R9

  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_req && clk_q == park_req) |=> $stable(clk_q)); // R6

  AST_RUN_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (run_req && phase_end) |=> (clk_q != $past(clk_q))); // R8

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (SEG_W'(cnt_q) < half_of(act_q))); // R2
endmodule

// File: rtl/card_clk_gen.sv
module card_clk_gen #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              prog_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dsel,
  output logic              card_clk,
  output logic              vsel_5v
);
  logic [ADDR_W-1:0] ratio_w;
  logic              run_w;
  logic              park_w;

  ccg_prog_if #(.ADDR_W(ADDR_W)) u_prog (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_n),
    .prog_n   (prog_n),
    .addr     (addr),
    .dsel     (dsel),
    .ratio_q  (ratio_w),
    .supply_q (vsel_5v),
    .run_q    (run_w),
    .park_q   (park_w)
  );

  ccg_phase_div #(.ADDR_W(ADDR_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .ratio_req (ratio_w),
    .run_req   (run_w),
    .park_req  (park_w),
    .clk_q     (card_clk)
  );

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!card_clk && !vsel_5v)); // R1
endmodule

// File: tb/card_clk_gen_test.sv
module card_clk_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1;
  logic       prog_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic       dsel = 1'b0;
  wire        card_clk;
  wire        vsel_5v;

  int n_run = 0;
  int n_fail = 0;
  bit timeout = 0;

  always #2.5 clk = ~clk;

  card_clk_gen uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .prog_n(prog_n),
    .addr(addr), .dsel(dsel), .card_clk(card_clk), .vsel_5v(vsel_5v)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit pg, input logic [1:0] a, input bit d);
    @(negedge clk); prog_n = pg; addr = a; dsel = d; sel_n = 1'b1;
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); prog_n = 1'b1;
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic meas(output int hi, output int lo);
    int guard = 0;
    while (card_clk !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (card_clk !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    hi = 0;
    while (card_clk === 1'b1 && hi < 200) begin hi++; @(negedge clk); end
    lo = 0;
    while (card_clk === 1'b0 && lo < 200) begin lo++; @(negedge clk); end
  endtask

  task automatic steady(input int n, output bit stuck, output logic lvl);
    lvl = card_clk;
    stuck = 1'b1;
    repeat (n) begin
      @(negedge clk);
      if (card_clk !== lvl) stuck = 1'b0;
    end
  endtask

  // shortest complete phase seen over n samples; first partial phase skipped
  task automatic watch(input int n, output int mn);
    logic prev = card_clk;
    int run = 1000;
    mn = 1000;
    repeat (n) begin
      @(negedge clk);
      if (card_clk !== prev) begin
        if (run < mn) mn = run;
        run = 1;
      end else run++;
      prev = card_clk;
    end
  endtask

  task automatic check_period(input int half, input string req);
    int hi, lo;
    meas(hi, lo);
    chk(hi == half, req, hi, half);
    chk(lo == half, req, lo, half);
  endtask

  task automatic main_seq;
    bit   stuck;
    logic lvl;
    int   mn;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(card_clk === 1'b0, "R1 clk after reset", card_clk, 0);
    chk(vsel_5v === 1'b0, "R1 supply after reset", vsel_5v, 0);
    steady(30, stuck, lvl);
    chk(stuck && lvl === 1'b0, "R1 parked low", lvl, 0);
    wr(1'b1, 2'b10, 1'b0);
    idle(10);
    check_period(1, "R1 default ratio /1");

    // R2 R3 sweep over every ratio code and supply value
    for (int r = 0; r < 4; r++) begin
      for (int d = 0; d < 2; d++) begin
        wr(1'b0, 2'(r), 1'(d));
        idle(20);
        check_period(1 << r, "R2 ratio sweep");
        check_period(1 << r, "R2 ratio sweep repeat");
        chk(vsel_5v === 1'(d), "R3 supply select", vsel_5v, d);
      end
    end

    // R9 ratio changes while running never truncate a phase
    fork
      wr(1'b0, 2'b01, 1'b0);
      watch(80, mn);
    join
    chk(mn >= 2, "R9 /8 to /2 min phase", mn, 2);
    check_period(2, "R9 after /8 to /2");
    fork
      wr(1'b0, 2'b11, 1'b0);
      watch(80, mn);
    join
    chk(mn >= 2, "R9 /2 to /8 min phase", mn, 2);
    check_period(8, "R9 after /2 to /8");

    // R6 park low from running /4
    wr(1'b0, 2'b10, 1'b0);
    idle(20);
    fork
      wr(1'b1, 2'b00, 1'b0);
      watch(40, mn);
    join
    chk(mn >= 4, "R6 min phase on stop", mn, 4);
    steady(40, stuck, lvl);
    chk(stuck && lvl === 1'b0, "R6 parked low", lvl, 0);

    // R7 park high from parked low
    wr(1'b1, 2'b01, 1'b0);
    idle(20);
    steady(40, stuck, lvl);
    chk(stuck && lvl === 1'b1, "R7 parked high", lvl, 1);
    wr(1'b1, 2'b00, 1'b0);
    idle(20);
    steady(30, stuck, lvl);
    chk(stuck && lvl === 1'b0, "R6 high to low park", lvl, 0);

    // R10 program while parked, then restart
    wr(1'b0, 2'b11, 1'b1);
    steady(30, stuck, lvl);
    chk(stuck && lvl === 1'b0, "R10 stays parked", lvl, 0);
    chk(vsel_5v === 1'b1, "R10 supply while parked", vsel_5v, 1);
    wr(1'b1, 2'b11, 1'b0);
    steady(30, stuck, lvl);
    chk(stuck && lvl === 1'b0, "R8 nop keeps park", lvl, 0);
    wr(1'b1, 2'b10, 1'b0);
    idle(10);
    check_period(8, "R10 new ratio on restart");
    wr(1'b1, 2'b11, 1'b0);
    check_period(8, "R8 nop keeps running");

    // R4 only the falling edge captures
    wr(1'b0, 2'b00, 1'b0);
    @(negedge clk); prog_n = 1'b0; addr = 2'b01; dsel = 1'b1; sel_n = 1'b1;
    @(negedge clk); sel_n = 1'b0;
    @(negedge clk); prog_n = 1'b1; addr = 2'b11; dsel = 1'b0;
    idle(3);
    prog_n = 1'b0; addr = 2'b10;
    idle(3);
    prog_n = 1'b1; addr = 2'b00;
    idle(3);
    sel_n = 1'b1;
    idle(20);
    chk(vsel_5v === 1'b1, "R4 supply from edge", vsel_5v, 1);
    check_period(2, "R4 ratio from edge");

    // R5 select inactive: sweep all bus values
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      {prog_n, addr, dsel} = 4'(i);
      @(negedge clk);
    end
    prog_n = 1'b1; addr = 2'b00; dsel = 1'b0;
    idle(10);
    chk(vsel_5v === 1'b1, "R5 supply untouched", vsel_5v, 1);
    check_period(2, "R5 clock untouched");
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule